// File: doc/BRIEF.md
# Dual signed multiply-subtract accumulator

This datapath unit treats each of two 32-bit source words as a pair of signed 16-bit halfwords. It forms two signed 16×16 products and subtracts the upper-lane product from the lower-lane product. It then adds that difference to a 64-bit accumulator, which arrives as a low word and a high word. A control bit can exchange the two halfwords of the second source before the multiplications, so the products become crossed (low×high and high×low) instead of straight (low×low and high×high).

The caller presents operands and raises `start_i` for one cycle. One clock later the 64-bit result appears as a high/low word pair on registered outputs, and `done_o` pulses. The result then holds until the next start. The 64-bit addition wraps silently. No overflow flag exists.

Top module: `dmsa_unit`

## Requirements
- R1: While `rst_n` is low, `res_lo_o`, `res_hi_o` and `done_o` are all zero.
- R2: `done_o` is high in exactly the cycle after a cycle with `start_i` high, and low otherwise.
- R3: With `xchg_i` = 0, the added value is A[15:0]·B[15:0] − A[31:16]·B[31:16], with every halfword read as signed two's complement.
- R4: With `xchg_i` = 1, the added value is A[15:0]·B[31:16] − A[31:16]·B[15:0], with every halfword read as signed.
- R5: The added value is sign-extended to 64 bits and summed with the accumulator {`acc_hi_i`,`acc_lo_i`}. Bits 63:32 of the sum go to `res_hi_o` and bits 31:0 go to `res_lo_o`.
- R6: The 64-bit sum wraps modulo 2^64, for example when the accumulator sits at the signed maximum or minimum. No port shows the overflow.
- R7: In cycles without `start_i`, the result outputs keep their value.
- R8: When all four halfwords are −32768, each product is +2^30, and the added value is 0 in both exchange modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Accept the operands this cycle |
| xchg_i | input | 1 | 1 = exchange halfwords of the second source |
| op_a_i | input | 32 | First source, two signed halfwords |
| op_b_i | input | 32 | Second source, two signed halfwords |
| acc_lo_i | input | 32 | Accumulator bits 31:0 |
| acc_hi_i | input | 32 | Accumulator bits 63:32 |
| res_lo_o | output | 32 | Result bits 31:0 |
| res_hi_o | output | 32 | Result bits 63:32 |
| done_o | output | 1 | Result-valid pulse |

## Verification
The bench runs a behavioural model and compares it with the outputs on every cycle. With a single register stage, any fault shows up one clock after the start that exposes it.

Each kind of fault has its own signature:
- A wrong lane route or a missing sign extension corrupts the low word, or flips the whole high word to all ones or all zeros.
- A broken hold enable makes the result drift in the idle cycle that follows each operation.
- A bad done register shows as a missing or doubled pulse.

Stimulus covers both exchange modes, the −32768 corners, and accumulators at both signed limits.

// File: rtl/dmsa_pkg.sv
package dmsa_pkg;
  localparam int unsigned DMSA_HALF_W = 16;

  typedef enum logic {
    ROUTE_STRAIGHT = 1'b0,
    ROUTE_CROSSED  = 1'b1
  } route_e;
endpackage

// File: rtl/dmsa_route.sv
module dmsa_route
  import dmsa_pkg::*;
#(
  parameter int unsigned HALF_W = DMSA_HALF_W,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0] src_i,
  input  route_e            mode_i,
  output logic [HALF_W-1:0] lane_lo_o,
  output logic [HALF_W-1:0] lane_hi_o
);
  always_comb begin
    if (mode_i == ROUTE_CROSSED) begin
      lane_lo_o = src_i[WORD_W-1:HALF_W];
      lane_hi_o = src_i[HALF_W-1:0];
    end else begin
      lane_lo_o = src_i[HALF_W-1:0];
      lane_hi_o = src_i[WORD_W-1:HALF_W];
    end
  end
endmodule

// File: rtl/dmsa_lane_mul.sv
module dmsa_lane_mul
  import dmsa_pkg::*;
#(
  parameter int unsigned HALF_W = DMSA_HALF_W,
  localparam int unsigned PROD_W = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] x_i,
  input  logic [HALF_W-1:0] y_i,
  output logic [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] x_ext;
  logic signed [PROD_W-1:0] y_ext;

  always_comb begin
    x_ext  = PROD_W'(signed'(x_i));
    y_ext  = PROD_W'(signed'(y_i));
    prod_o = x_ext * y_ext;
  end
endmodule

// File: rtl/dmsa_accum.sv
module dmsa_accum
  import dmsa_pkg::*;
#(
  parameter int unsigned HALF_W = DMSA_HALF_W,
  localparam int unsigned PROD_W = 2 * HALF_W,
  localparam int unsigned DIFF_W = PROD_W + 1,
  localparam int unsigned ACC_W  = 4 * HALF_W
) (
  input  logic [PROD_W-1:0] prod_lo_i,
  input  logic [PROD_W-1:0] prod_hi_i,
  input  logic [ACC_W-1:0]  acc_i,
  output logic [ACC_W-1:0]  sum_o
);
  logic [DIFF_W-1:0] diff;
  logic [ACC_W-1:0]  diff_ext;

  always_comb begin
    diff     = {prod_lo_i[PROD_W-1], prod_lo_i} - {prod_hi_i[PROD_W-1], prod_hi_i};
    diff_ext = {{(ACC_W-DIFF_W){diff[DIFF_W-1]}}, diff};
    sum_o    = acc_i + diff_ext;
  end
endmodule

// File: rtl/dmsa_unit.sv
module dmsa_unit
  import dmsa_pkg::*;
#(
  parameter int unsigned HALF_W = DMSA_HALF_W,
  localparam int unsigned WORD_W = 2 * HALF_W,
  localparam int unsigned PROD_W = 2 * HALF_W,
  localparam int unsigned ACC_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              xchg_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  input  logic [WORD_W-1:0] acc_lo_i,
  input  logic [WORD_W-1:0] acc_hi_i,
  output logic [WORD_W-1:0] res_lo_o,
  output logic [WORD_W-1:0] res_hi_o,
  output logic              done_o
);
  logic [HALF_W-1:0] a_lane [2];
  logic [HALF_W-1:0] b_lane [2];
  logic [PROD_W-1:0] prod   [2];
  logic [ACC_W-1:0]  sum;
  logic [ACC_W-1:0]  res_d, res_q;
  logic              done_d, done_q;
  route_e            mode;

  assign mode      = route_e'(xchg_i);
  assign a_lane[0] = op_a_i[HALF_W-1:0];
  assign a_lane[1] = op_a_i[WORD_W-1:HALF_W];

  dmsa_route #(.HALF_W(HALF_W)) i_route (
    .src_i     (op_b_i),
    .mode_i    (mode),
    .lane_lo_o (b_lane[0]),
    .lane_hi_o (b_lane[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    dmsa_lane_mul #(.HALF_W(HALF_W)) i_mul (
      .x_i    (a_lane[g]),
      .y_i    (b_lane[g]),
      .prod_o (prod[g])
    );
  end

  dmsa_accum #(.HALF_W(HALF_W)) i_accum (
    .prod_lo_i (prod[0]),
    .prod_hi_i (prod[1]),
    .acc_i     ({acc_hi_i, acc_lo_i}),
    .sum_o     (sum)
  );

  // next-state
  always_comb begin
    res_d  = res_q;
    done_d = start_i;
    if (start_i) res_d = sum;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (start_i) res_q <= res_d;
    end
  end

  assign res_lo_o = res_q[WORD_W-1:0];
  assign res_hi_o = res_q[ACC_W-1:WORD_W];
  assign done_o   = done_q;

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o); // R2
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o); // R2
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable({res_hi_o, res_lo_o})); // R7
  AST_ZERO_SRC_PASSES_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_b_i == '0) |=> {res_hi_o, res_lo_o} == $past({acc_hi_i, acc_lo_i})); // R5
  AST_MIN_CORNER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_a_i == {2{1'b1, {(HALF_W-1){1'b0}}}} && op_b_i == {2{1'b1, {(HALF_W-1){1'b0}}}})
    |=> {res_hi_o, res_lo_o} == $past({acc_hi_i, acc_lo_i})); // R8
endmodule

// File: tb/test_dmsa_unit.sv
module test_dmsa_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, xchg_i;
  logic [31:0] op_a_i, op_b_i, acc_lo_i, acc_hi_i;
  logic [31:0] res_lo_o, res_hi_o;
  logic        done_o;

  int          checks = 0;
  int          bad = 0;
  int          cyc = 0;
  string       tag = "R1";
  logic [63:0] exp_res = '0;
  logic        exp_done = 1'b0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  dmsa_unit i_dmsa_unit (
    .clk, .rst_n, .start_i, .xchg_i, .op_a_i, .op_b_i,
    .acc_lo_i, .acc_hi_i, .res_lo_o, .res_hi_o, .done_o
  );

  function automatic longint h(input logic [15:0] v);
    return longint'($signed(v));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_res  <= '0;
      exp_done <= 1'b0;
    end else begin
      exp_done <= start_i;
      if (start_i) begin
        longint d;
        if (xchg_i)
          d = h(op_a_i[15:0]) * h(op_b_i[31:16]) - h(op_a_i[31:16]) * h(op_b_i[15:0]);
        else
          d = h(op_a_i[15:0]) * h(op_b_i[15:0]) - h(op_a_i[31:16]) * h(op_b_i[31:16]);
        exp_res <= {acc_hi_i, acc_lo_i} + 64'(d);
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if ({res_hi_o, res_lo_o} !== exp_res || done_o !== exp_done) begin
        bad++;
        $display("FAIL %s: got res=%h done=%b expected res=%h done=%b",
                 tag, {res_hi_o, res_lo_o}, done_o, exp_res, exp_done);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      bad++;
      $display("FAIL watchdog R2: got cycle=%0d expected under 100000", cyc);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic op(input logic [31:0] a, input logic [31:0] b, input logic x,
                    input logic [63:0] acc, input string t);
    @(negedge clk);
    tag = t;
    op_a_i = a; op_b_i = b; xchg_i = x;
    {acc_hi_i, acc_lo_i} = acc;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    op_a_i = ~a; acc_lo_i = ~acc_lo_i; // R7: idle change must not reach outputs
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; xchg_i = 1'b0;
    op_a_i = '1; op_b_i = '1; acc_lo_i = '1; acc_hi_i = '1;
    repeat (3) @(negedge clk);       // R1 reset state compared each cycle
    @(posedge clk); #1 rst_n = 1'b1;

    op(32'h0003_0005, 32'h0002_0007, 1'b0, 64'd100, "R3");
    op(32'hFFFF_0004, 32'h0009_FFFE, 1'b0, 64'd0, "R3");
    op(32'h0003_0005, 32'h0002_0007, 1'b1, 64'd100, "R4");
    op(32'h8000_7FFF, 32'h7FFF_8000, 1'b1, 64'd0, "R4");
    op(32'h8000_8000, 32'h8000_8000, 1'b0, 64'h1234_5678_9ABC_DEF0, "R8");
    op(32'h8000_8000, 32'h8000_8000, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    op(32'h0001_8000, 32'h7FFF_7FFF, 1'b0, 64'h0000_0000_0000_0010, "R5");
    op(32'h1234_5678, 32'h0000_0000, 1'b1, 64'hDEAD_BEEF_0BAD_F00D, "R5");
    op(32'h0000_7FFF, 32'h0000_7FFF, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, "R6");
    op(32'h7FFF_0000, 32'h7FFF_0000, 1'b0, 64'h8000_0000_0000_0000, "R6");
    op(32'h8000_7FFF, 32'h8000_7FFF, 1'b1, 64'hFFFF_FFFF_C000_0000, "R6");
    for (int k = 0; k < 300; k++) begin
      op($urandom, $urandom, 1'($urandom), {$urandom, $urandom}, (k % 2) ? "R4" : "R3");
      if (k % 7 == 0) begin
        tag = "R7";
        repeat (3) @(negedge clk);
      end
    end
    tag = "R2";
    @(negedge clk); start_i = 1'b1; op_a_i = 32'h0002_0003; op_b_i = 32'h0004_0005;
    {acc_hi_i, acc_lo_i} = 64'd1; xchg_i = 1'b0;
    repeat (3) @(negedge clk);       // back-to-back starts
    start_i = 1'b0;
    repeat (3) @(negedge clk);

    tag = "R1";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule